// File: doc/BRIEF.md
# Sample Averaging Conversion Controller

This block sits between a sample source and the register file of a converter. After a start pulse it asks for samples and takes each one offered with a valid strobe. With averaging off, every accepted sample is a finished result. With averaging on, it forms the rounded mean of a set of 4, 8, 16 or 32 samples. That mean is the finished result.

Each finished result loads the result output and sets a sticky completion flag. When enabled, it also drives an interrupt level and a one-cycle DMA request.

In single mode the block goes idle after one result. In continuous mode it keeps collecting results or whole sets back to back until software turns continuous mode off. A new start at any time throws away a partly collected set and begins again. The averaging choice is taken at that start.

Top module: `smp_avg_ctl`

## Requirements
- R1: With averaging off, each sample accepted (busy high, valid high, no start in that cycle) appears on `result` and sets `done_flag` in the cycle after it is taken.
- R2: With averaging on, `avg_sel` selects the set size: 00 means 4 samples, 01 means 8, 10 means 16 and 11 means 32. The result is (sum + N/2) >> log2(N), the mean rounded to nearest with halves rounding up, and it is reported once per full set.
- R3: With `cont_mode` low, `busy` falls in the cycle after a result is finished. Samples offered while idle change neither `result` nor `done_flag`.
- R4: With `cont_mode` high, `busy` stays high after a result. Further results or whole sets are collected and reported one after another without a new start.
- R5: `done_flag` is set by each finished result. It is cleared by `rd_result` or by `start`. When a read and a finish fall in the same cycle, the finish wins and the flag stays set.
- R6: `irq` is high exactly when `done_flag` and `irq_en` are both high.
- R7: When `dma_en` is high, `dma_req` pulses high for one cycle, in the same cycle that `done_flag` takes up the new result. When `dma_en` is low, `dma_req` stays low.
- R8: A `start` while busy restarts the set from empty. Samples collected before it are discarded, and a sample offered in the start cycle itself is not taken.
- R9: `avg_en` and `avg_sel` are captured at `start`. Changing them during a set does not change that set's size.
- R10: After reset, `busy`, `smp_req`, `done_flag`, `irq`, `dma_req` and `result` are all zero. `smp_req` follows `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | 16 | Raw sample value |
| smp_valid | input | 1 | Sample on `smp_data` is valid this cycle |
| avg_en | input | 1 | Averaging on (captured at start) |
| avg_sel | input | 2 | Set size select (captured at start) |
| cont_mode | input | 1 | Repeat results or sets after one start |
| start | input | 1 | Begin or restart collection (one-cycle pulse) |
| rd_result | input | 1 | Result read strobe, clears the completion flag |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| smp_req | output | 1 | Block wants samples |
| result | output | 16 | Latest finished result |
| done_flag | output | 1 | Sticky completion flag |
| busy | output | 1 | Collection in progress |
| irq | output | 1 | Completion interrupt level |
| dma_req | output | 1 | One-cycle DMA request per result |

## Verification
The case that needs care is a result read and a new result finishing in the same cycle. The bench runs in continuous mode with averaging off and pulses `rd_result` in the very cycle the next sample is taken. It then expects `done_flag` still set and `result` holding the new sample. A second overlap is a restart pulse in the same cycle as a valid sample. In that case the sample must not join the fresh set, and the rounded mean of the following four samples shows whether it leaked in.

// File: rtl/smp_avg_pkg.sv
package smp_avg_pkg;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = 2;
    localparam int MIN_LOG = 2;
endpackage

// File: rtl/smp_seq.sv
module smp_seq #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cont_mode,
    input  logic             avg_en,
    input  logic [SEL_W-1:0] avg_sel,
    input  logic             smp_valid,
    input  logic             done_evt,
    output logic             busy,
    output logic             accept,
    output logic             cfg_avg,
    output logic [SEL_W-1:0] cfg_sel
);
    typedef struct packed {
        logic             busy;
        logic             avg;
        logic [SEL_W-1:0] sel;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.avg  = avg_en;
            st_d.sel  = avg_sel;
        end else if (done_evt && !cont_mode) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign accept  = st_q.busy && smp_valid && !start;
    assign cfg_avg = st_q.avg;
    assign cfg_sel = st_q.sel;

    // R3
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !cont_mode && !start) |=> !busy);
    // R4
    cont_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && cont_mode) |=> busy);
endmodule

// File: rtl/smp_accum.sv
module smp_accum #(
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 2,
    parameter int MIN_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              accept,
    input  logic              avg_on,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] sample,
    output logic              done_evt,
    output logic [DATA_W-1:0] value
);
    localparam int N_OPT   = 1 << SEL_W;
    localparam int MAX_LOG = MIN_LOG + N_OPT - 1;
    localparam int ACC_W   = DATA_W + MAX_LOG;
    localparam int CNT_W   = MAX_LOG;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [ACC_W-1:0]  sum_next;
    logic [CNT_W-1:0]  last_cnt;
    logic              set_end;
    logic [DATA_W-1:0] avg_opt [N_OPT];

    assign sum_next = st_q.acc + ACC_W'(sample);

    always_comb begin
        last_cnt = CNT_W'((32'd1 << (MIN_LOG + int'(sel))) - 32'd1);
    end

    for (genvar g = 0; g < N_OPT; g++) begin : g_round
        localparam int SH = MIN_LOG + g;
        logic [ACC_W-1:0] rounded;
        assign rounded    = sum_next + ACC_W'(32'd1 << (SH - 1));
        assign avg_opt[g] = DATA_W'(rounded >> SH);
    end

    assign set_end  = accept && (!avg_on || (st_q.cnt == last_cnt));
    assign done_evt = set_end;
    assign value    = avg_on ? avg_opt[sel] : sample;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '0;
        end else if (accept && avg_on) begin
            if (st_q.cnt == last_cnt) begin
                st_d = '0;
            end else begin
                st_d.acc = sum_next;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_cnt);
    // R8
    restart_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0 && st_q.acc == '0));
endmodule

// File: rtl/smp_flags.sv
module smp_flags #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_evt,
    input  logic [DATA_W-1:0] value,
    input  logic              rd_result,
    input  logic              start,
    input  logic              irq_en,
    input  logic              dma_en,
    output logic [DATA_W-1:0] result,
    output logic              done_flag,
    output logic              irq,
    output logic              dma_req
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              done;
        logic              dma;
    } flg_st_t;

    flg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.dma = done_evt && dma_en;
        if (done_evt) begin
            st_d.done = 1'b1;
            st_d.res  = value;
        end else if (rd_result || start) begin
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result    = st_q.res;
    assign done_flag = st_q.done;
    assign dma_req   = st_q.dma;
    assign irq       = st_q.done && irq_en;

    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_result && !done_evt) |=> !done_flag);
    // R5
    finish_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> done_flag);
    // R7
    dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> done_flag);
endmodule

// File: rtl/smp_avg_ctl.sv
module smp_avg_ctl
    import smp_avg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic              avg_en,
    input  logic [SEL_W-1:0]  avg_sel,
    input  logic              cont_mode,
    input  logic              start,
    input  logic              rd_result,
    input  logic              irq_en,
    input  logic              dma_en,
    output logic              smp_req,
    output logic [DATA_W-1:0] result,
    output logic              done_flag,
    output logic              busy,
    output logic              irq,
    output logic              dma_req
);
    logic             accept;
    logic             done_evt;
    logic             cfg_avg;
    logic [SEL_W-1:0] cfg_sel;
    logic [DATA_W-1:0] value;

    smp_seq #(.SEL_W(SEL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cont_mode (cont_mode),
        .avg_en    (avg_en),
        .avg_sel   (avg_sel),
        .smp_valid (smp_valid),
        .done_evt  (done_evt),
        .busy      (busy),
        .accept    (accept),
        .cfg_avg   (cfg_avg),
        .cfg_sel   (cfg_sel)
    );

    smp_accum #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MIN_LOG(MIN_LOG)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start),
        .accept   (accept),
        .avg_on   (cfg_avg),
        .sel      (cfg_sel),
        .sample   (smp_data),
        .done_evt (done_evt),
        .value    (value)
    );

    smp_flags #(.DATA_W(DATA_W)) u_flg (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_evt  (done_evt),
        .value     (value),
        .rd_result (rd_result),
        .start     (start),
        .irq_en    (irq_en),
        .dma_en    (dma_en),
        .result    (result),
        .done_flag (done_flag),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    assign smp_req = busy;

    // R10
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !dma_req);
endmodule

// File: tb/smp_avg_ctl_tb.sv
`timescale 1ns/1ps
module smp_avg_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        avg_en = 1'b0;
    logic [1:0]  avg_sel = '0;
    logic        cont_mode = 1'b0;
    logic        start = 1'b0;
    logic        rd_result = 1'b0;
    logic        irq_en = 1'b1;
    logic        dma_en = 1'b1;
    logic        smp_req, done_flag, busy, irq, dma_req;
    logic [15:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    smp_avg_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .avg_en(avg_en), .avg_sel(avg_sel), .cont_mode(cont_mode), .start(start),
        .rd_result(rd_result), .irq_en(irq_en), .dma_en(dma_en),
        .smp_req(smp_req), .result(result), .done_flag(done_flag), .busy(busy),
        .irq(irq), .dma_req(dma_req)
    );

    localparam int NV = 7;
    localparam int V_AVG  [NV] = '{0, 1, 1, 1, 1, 1, 1};
    localparam int V_SEL  [NV] = '{0, 0, 0, 1, 2, 3, 3};
    localparam int V_BASE [NV] = '{4660, 1, 100, 1000, 65535, 0, 65500};
    localparam int V_STEP [NV] = '{0, 1, 3, 7, 0, 1, 1};

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic send(int d);
        smp_valid = 1'b1;
        smp_data  = 16'(d);
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 smp_req", smp_req, 0);
        chk("R10 done_flag", done_flag, 0);
        chk("R10 irq", irq, 0);
        chk("R10 dma_req", dma_req, 0);
        chk("R10 result", result, 0);
        rst_n = 1'b1;
        tick();

        // R1 R2 R6 R7 R3: vector table
        for (int i = 0; i < NV; i++) begin
            int n, lg, s, exp;
            longint sum;
            avg_en  = V_AVG[i][0];
            avg_sel = 2'(V_SEL[i]);
            pulse_start();
            chk("R10 smp_req follows busy", smp_req, 1);
            lg  = V_SEL[i] + 2;
            n   = V_AVG[i] != 0 ? (1 << lg) : 1;
            sum = 0;
            s   = 0;
            for (int k = 0; k < n; k++) begin
                s = V_BASE[i] + k * V_STEP[i];
                sum += s;
                send(s);
            end
            exp = V_AVG[i] != 0 ? int'((sum + longint'(n / 2)) >> lg) : s;
            chk(V_AVG[i] != 0 ? "R2 averaged result" : "R1 single result", result, exp);
            chk("R5 done set", done_flag, 1);
            chk("R6 irq", irq, 1);
            chk("R7 dma pulse", dma_req, 1);
            chk("R3 busy drops", busy, 0);
            tick();
            chk("R7 dma one cycle", dma_req, 0);
        end

        // R5 read clears the flag
        rd_result = 1'b1;
        tick();
        rd_result = 1'b0;
        chk("R5 read clears", done_flag, 0);
        chk("R6 irq follows flag", irq, 0);

        // R5 R1 R4: read and finish in the same cycle
        avg_en = 1'b0;
        cont_mode = 1'b1;
        pulse_start();
        send(111);
        chk("R1 cont first", result, 111);
        rd_result = 1'b1;
        send(222);
        rd_result = 1'b0;
        chk("R5 finish beats read", done_flag, 1);
        chk("R1 result on overlap", result, 222);
        chk("R4 still busy", busy, 1);
        cont_mode = 1'b0;
        send(333);
        chk("R3 stop after result", busy, 0);
        chk("R1 last result", result, 333);
        send(444);
        chk("R3 idle sample ignored", result, 333);
        chk("R3 idle flag kept", done_flag, 1);

        // R5 start clears the flag
        pulse_start();
        chk("R5 start clears", done_flag, 0);

        // R8 R9 restart while busy, settings captured at start
        avg_en = 1'b1;
        avg_sel = 2'b00;
        pulse_start();
        send(1000);
        send(1000);
        start = 1'b1;
        smp_valid = 1'b1;
        smp_data = 16'd60000;
        tick();
        start = 1'b0;
        smp_valid = 1'b0;
        avg_sel = 2'b11;
        send(8);
        send(8);
        send(8);
        chk("R8 not finished early", done_flag, 0);
        send(8);
        chk("R8 partial discarded", result, 8);
        chk("R9 set size latched", done_flag, 1);
        chk("R9 busy ends after four", busy, 0);

        // R6 interrupt gating
        irq_en = 1'b0;
        #1;
        chk("R6 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk("R6 irq unmasked", irq, 1);

        // R7 dma disabled
        dma_en = 1'b0;
        avg_en = 1'b0;
        pulse_start();
        send(5);
        chk("R7 dma off", dma_req, 0);
        chk("R1 result with dma off", result, 5);
        dma_en = 1'b1;

        // R4 continuous averaged sets
        avg_en = 1'b1;
        avg_sel = 2'b00;
        cont_mode = 1'b1;
        pulse_start();
        send(10); send(20); send(30); send(40);
        chk("R4 first set", result, 25);
        chk("R4 busy after set", busy, 1);
        send(1); send(1); send(1); send(2);
        chk("R4 second set", result, 1);
        chk("R4 dma second set", dma_req, 1);
        cont_mode = 1'b0;
        send(7); send(7); send(7); send(7);
        chk("R4 final set", result, 7);
        chk("R3 busy after final", busy, 0);

        tick();
        finish_run();
    end
endmodule